// File: doc/BRIEF.md
# Typed Packed-SIMD Integer Register File

This block is the integer register file of a small core that runs packed SIMD work in its ordinary registers. It has 32 entries of 32 bits. Vector register N and integer register N are the same storage, so no separate vector file exists. Each entry also holds a two-bit element-type tag. The tag tells the lane logic how to split the word: four 8-bit lanes, two 16-bit lanes, or one signed 32-bit value. Each of the two read ports returns the register word together with its tag.

After reset the tag map is fixed. Registers whose specifier has a clear top bit hold 8-bit lanes. Registers whose specifier has a set top bit hold 16-bit lanes, except the two highest registers, which hold one signed 32-bit value. Software can retype any register through a separate configuration port. A small classifier looks at the addressing mode of each vector memory instruction. It raises a registered trap flag for every mode other than unit-stride, so that strided and indexed transfers can be emulated in software.

Top module: `typed_simd_rf`

## Requirements
- R1: A synchronous active-high reset clears every data word to zero. On the next cycle every tag holds its default value again.
- R2: Tag encoding: 2'b00 means 4x8-bit, 2'b01 means 2x16-bit, 2'b10 means 1x signed 32-bit. The default tag is 2'b00 for registers 0 to 15, 2'b01 for registers 16 to 29, and 2'b10 for registers 30 and 31.
- R3: A write of data D to register N (N not 0) returns D on both read ports from the next cycle on.
- R4: A read of register N in the same cycle as a write to N returns the new write data on that read port (write-first).
- R5: Register 0 always reads zero. A write to register 0 has no effect. The tag of register 0 is still reported.
- R6: A configuration write of tag T to register N shows on the read ports from the next cycle on. In the cycle of the write, the old tag is still shown.
- R7: A configuration write with the reserved value 2'b11 leaves the tag of its target unchanged.
- R8: A configuration write never changes data. A data write never changes a tag.
- R9: One cycle after a memory instruction is presented with valid high, the trap output is high if the mode is 2'b01 (strided), 2'b10 (indexed) or 2'b11 (reserved). It is low if the mode is 2'b00 (unit-stride). It is also low one cycle after a cycle with valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Read port A register specifier |
| rd_data_a | output | 32 | Read port A data |
| rd_type_a | output | 2 | Read port A element-type tag |
| rd_addr_b | input | 5 | Read port B register specifier |
| rd_data_b | output | 32 | Read port B data |
| rd_type_b | output | 2 | Read port B element-type tag |
| wr_en | input | 1 | Data write enable |
| wr_addr | input | 5 | Data write register specifier |
| wr_data | input | 32 | Data write value |
| cfg_en | input | 1 | Tag configuration write enable |
| cfg_addr | input | 5 | Register whose tag is rewritten |
| cfg_type | input | 2 | New tag value |
| mem_valid | input | 1 | Memory instruction valid strobe |
| mem_mode | input | 2 | Memory addressing mode |
| mem_trap | output | 1 | Unsupported-mode trap, registered |

## Verification
The read data and read tags are combinational on the current state and the write inputs. They are sampled one time unit after the inputs change at the falling edge, which covers the same-cycle bypass. Data and tag writes show on the following cycle. The bench model applies them at the rising edge and compares the outputs in the next cycle, so a tag write is checked both before and after it takes effect. The trap flag depends on the inputs held across one rising edge. It is compared at the next falling edge against a value computed from those inputs.

// File: rtl/simd_rf_pkg.sv
package simd_rf_pkg;

    typedef enum logic [1:0] {
        ELEM_8X4  = 2'b00,
        ELEM_16X2 = 2'b01,
        ELEM_32X1 = 2'b10,
        ELEM_RSVD = 2'b11
    } elem_t;

    typedef enum logic [1:0] {
        MEM_UNIT   = 2'b00,
        MEM_STRIDE = 2'b01,
        MEM_INDEX  = 2'b10,
        MEM_RSVD   = 2'b11
    } mem_mode_t;

endpackage

// File: rtl/simd_rf_tags.sv
module simd_rf_tags
    import simd_rf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_type,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [1:0]        rd_type_a,
    output logic [1:0]        rd_type_b
);

    typedef logic [NUM_REGS-1:0][1:0] tag_map_t;

    typedef struct packed {
        tag_map_t tag;
    } tag_state_t;

    // Reset map: top two entries hold one wide value, the upper half holds
    // halfword lanes, the lower half holds byte lanes.
    function automatic tag_map_t build_default_map();
        tag_map_t m;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i >= NUM_REGS - 2)
                m[i] = ELEM_32X1;
            else if (((i >> (ADDR_W - 1)) & 1) == 1)
                m[i] = ELEM_16X2;
            else
                m[i] = ELEM_8X4;
        end
        return m;
    endfunction

    localparam tag_map_t DEFAULT_MAP = build_default_map();

    tag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.tag = DEFAULT_MAP;
        end else if (cfg_en && (cfg_type != ELEM_RSVD)) begin
            state_d.tag[cfg_addr] = cfg_type;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd_type_a = state_q.tag[rd_addr_a];
    assign rd_type_b = state_q.tag[rd_addr_b];

    p_reset_default_r1: assert property (@(posedge clk)
        rst |=> (state_q.tag == DEFAULT_MAP))
        else $error("tag map not restored after reset");

    p_cfg_apply_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_type != ELEM_RSVD) |=> (state_q.tag[$past(cfg_addr)] == $past(cfg_type)))
        else $error("tag write not applied");

    p_reserved_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_type == ELEM_RSVD) |=> (state_q.tag == $past(state_q.tag)))
        else $error("reserved tag value changed the map");

    p_no_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(state_q.tag))
        else $error("tag map moved without a configuration write");

endmodule

// File: rtl/simd_rf_data.sv
module simd_rf_data
    import simd_rf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] word;
    } data_state_t;

    data_state_t state_d, state_q;
    logic        wr_live;

    assign wr_live = wr_en && (wr_addr != ZERO_REG);

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.word = '0;
        end else if (wr_live) begin
            state_d.word[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Two identical read ports, each with write-first forwarding.
    logic [1:0][ADDR_W-1:0] rd_addr;
    logic [1:0][DATA_W-1:0] rd_data;
    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == ZERO_REG)
                rd_data[p] = '0;
            else if (wr_live && (wr_addr == rd_addr[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = state_q.word[rd_addr[p]];
        end
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_q.word == '0))
        else $error("data not cleared by reset");

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wr_live |=> (state_q.word[$past(wr_addr)] == $past(wr_data)))
        else $error("write did not land");

    p_zero_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ZERO_REG) |=> (state_q.word == $past(state_q.word)))
        else $error("write to register zero changed storage");

endmodule

// File: rtl/simd_rf_memclass.sv
module simd_rf_memclass
    import simd_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_valid,
    input  logic [1:0] mem_mode,
    output logic       mem_trap
);

    typedef struct packed {
        logic trap;
    } cls_state_t;

    cls_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst)
            state_d.trap = 1'b0;
        else
            state_d.trap = mem_valid && (mem_mode != MEM_UNIT);
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign mem_trap = state_q.trap;

    p_trap_raise_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_mode != MEM_UNIT) |=> mem_trap)
        else $error("unsupported mode did not trap");

    p_unit_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_mode == MEM_UNIT) |=> !mem_trap)
        else $error("unit-stride access trapped");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_valid |=> !mem_trap)
        else $error("trap without valid instruction");

endmodule

// File: rtl/typed_simd_rf.sv
module typed_simd_rf
    import simd_rf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [1:0]        rd_type_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [1:0]        rd_type_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_type,
    input  logic              mem_valid,
    input  logic [1:0]        mem_mode,
    output logic              mem_trap
);

    simd_rf_data #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_data (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    simd_rf_tags #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_addr  (cfg_addr),
        .cfg_type  (cfg_type),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_type_a (rd_type_a),
        .rd_type_b (rd_type_b)
    );

    simd_rf_memclass u_memclass (
        .clk       (clk),
        .rst       (rst),
        .mem_valid (mem_valid),
        .mem_mode  (mem_mode),
        .mem_trap  (mem_trap)
    );

    p_tag_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_type_a != ELEM_RSVD) && (rd_type_b != ELEM_RSVD))
        else $error("reserved tag value reported");

endmodule

// File: tb/typed_simd_rf_test.sv
module typed_simd_rf_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr, cfg_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic [1:0]  rd_type_a, rd_type_b, cfg_type, mem_mode;
    logic        wr_en, cfg_en, mem_valid, mem_trap;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_data [32];
    logic [1:0]  m_tag  [32];
    logic        m_trap;

    always #5 clk = ~clk;

    typed_simd_rf uut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_type_a(rd_type_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .rd_type_b(rd_type_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_en(cfg_en), .cfg_addr(cfg_addr), .cfg_type(cfg_type),
        .mem_valid(mem_valid), .mem_mode(mem_mode), .mem_trap(mem_trap)
    );

    function automatic logic [1:0] dflt_tag(int r);
        if (r >= 30) return 2'b10;
        if (r >= 16) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_read(logic [4:0] a);
        if (a == 0) return 32'h0;
        if (wr_en && !rst && wr_addr == a) return wr_data;
        return m_data[a];
    endfunction

    function automatic string data_tag(logic [4:0] a);
        if (a == 0) return "R5";
        if (wr_en && wr_addr == a) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_addr = 0; wr_data = 0;
        cfg_en = 0; cfg_addr = 0; cfg_type = 0;
        mem_valid = 0; mem_mode = 0;
    endtask

    // Inputs are set at a falling edge before this is called.
    task automatic run_cycle(string type_req);
        #1;
        check(data_tag(rd_addr_a), rd_data_a, exp_read(rd_addr_a));
        check(data_tag(rd_addr_b), rd_data_b, exp_read(rd_addr_b));
        check(type_req, {30'h0, rd_type_a}, {30'h0, m_tag[rd_addr_a]});
        check(type_req, {30'h0, rd_type_b}, {30'h0, m_tag[rd_addr_b]});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 32; i++) begin
                m_data[i] = 0;
                m_tag[i]  = dflt_tag(i);
            end
            m_trap = 0;
        end else begin
            if (wr_en && wr_addr != 0) m_data[wr_addr] = wr_data;
            if (cfg_en && cfg_type != 2'b11) m_tag[cfg_addr] = cfg_type;
            m_trap = mem_valid && (mem_mode != 2'b00);
        end
        @(negedge clk);
        check("R9", {31'h0, mem_trap}, {31'h0, m_trap});
    endtask

    task automatic sweep_reset_state();
        for (int r = 0; r < 32; r++) begin
            rd_addr_a = 5'(r);
            rd_addr_b = 5'(31 - r);
            #1;
            check("R1", rd_data_a, 32'h0);
            check("R2", {30'h0, rd_type_a}, {30'h0, dflt_tag(r)});
            check("R2", {30'h0, rd_type_b}, {30'h0, dflt_tag(31 - r)});
            #1;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a_5e01));
        idle_inputs();
        rd_addr_a = 0; rd_addr_b = 0;
        rst = 1;
        for (int i = 0; i < 32; i++) begin m_data[i] = 0; m_tag[i] = dflt_tag(i); end
        m_trap = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        sweep_reset_state();

        // R5: write to register zero ignored; tag still reported
        wr_en = 1; wr_addr = 0; wr_data = 32'hdead_beef;
        rd_addr_a = 0; rd_addr_b = 0;
        run_cycle("R5");
        idle_inputs();
        rd_addr_a = 0; #1;
        check("R5", rd_data_a, 32'h0);
        check("R5", {30'h0, rd_type_a}, 32'h0);
        @(negedge clk);

        // R4: same-cycle bypass on both ports, then R3 on next cycle
        wr_en = 1; wr_addr = 7; wr_data = 32'h1234_5678;
        rd_addr_a = 7; rd_addr_b = 7;
        run_cycle("R2");
        idle_inputs();
        run_cycle("R3");

        // R6: tag write shows only on the next cycle
        cfg_en = 1; cfg_addr = 7; cfg_type = 2'b10;
        rd_addr_a = 7; #1;
        check("R6", {30'h0, rd_type_a}, 32'h0);
        run_cycle("R6");
        idle_inputs();
        rd_addr_a = 7; #1;
        check("R6", {30'h0, rd_type_a}, 32'h2);
        // R8: tag write left data intact
        check("R8", rd_data_a, 32'h1234_5678);
        @(negedge clk);

        // R7: reserved tag value ignored
        cfg_en = 1; cfg_addr = 20; cfg_type = 2'b11;
        run_cycle("R7");
        idle_inputs();
        rd_addr_a = 20; #1;
        check("R7", {30'h0, rd_type_a}, 32'h1);
        @(negedge clk);

        // R8: data write leaves tag of register 31 intact
        wr_en = 1; wr_addr = 31; wr_data = 32'hffff_0001;
        run_cycle("R8");
        idle_inputs();
        rd_addr_b = 31; #1;
        check("R8", {30'h0, rd_type_b}, 32'h2);
        check("R3", rd_data_b, 32'hffff_0001);
        @(negedge clk);

        // R9: each mode directed
        for (int m = 0; m < 4; m++) begin
            mem_valid = 1; mem_mode = 2'(m);
            run_cycle("R2");
        end
        idle_inputs();
        run_cycle("R9");

        // Constrained random traffic
        for (int n = 0; n < 2000; n++) begin
            wr_en     = ($urandom % 2) == 0;
            wr_addr   = 5'($urandom);
            wr_data   = $urandom;
            cfg_en    = ($urandom % 4) == 0;
            cfg_addr  = 5'($urandom);
            cfg_type  = 2'($urandom);
            mem_valid = ($urandom % 2) == 0;
            mem_mode  = 2'($urandom);
            rd_addr_a = (($urandom % 4) == 0) ? wr_addr : 5'($urandom);
            rd_addr_b = (($urandom % 8) == 0) ? cfg_addr : 5'($urandom);
            run_cycle("R6");
        end

        // R1: reset after traffic restores everything
        idle_inputs();
        rst = 1;
        run_cycle("R6");
        rst = 0;
        sweep_reset_state();
        check("R1", {31'h0, mem_trap}, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule